// File: doc/BRIEF.md
# SCSI Protocol Controller Register Core

This block is the byte-wide register and command engine of a legacy SCSI protocol controller. A host reaches it through a 16-offset register window. Reads and writes at one offset can mean different things: the transfer counter has a write-side copy and a read-side copy, and the status, interrupt and sequence offsets are read-only views. The core holds a small byte FIFO and a 16-bit transfer count, and drives a single level interrupt. A byte written to the command offset is decoded and applied in one clock. The decoded commands are no-op, FIFO flush, software reset, bus reset, transfer information, initiator command complete, message accept, pad, and the three selection forms.

The attached device is modelled by three plain inputs: whether a target answers selection, whether it has data to move, and the direction of that data. The external memory engine is modelled by a one-cycle `dma_start` strobe with a byte length, and a `dma_done` strobe that ends the transfer. The host bus accepts one access in every cycle and applies no back-pressure. Each read returns its byte one cycle later with `rd_valid`. That return path has no ready signal, so the host must take the byte in the cycle it is presented.

Top module: `scsi_reg_core`

## Requirements
- R1: After reset, offsets 0x0, 0x1, 0x3, 0x4, 0x5, 0x6 and 0x7 read 0x00, offset 0x8 (config) reads 0x07, offset 0xE reads the CHIP_ID parameter, and `irq` is low.
- R2: A read request (bus_valid=1, bus_write=0) returns on `rd_data` with `rd_valid` high exactly one cycle later. The byte reflects the register state in the cycle of the request.
- R3: Offset 0x2 writes push a byte into the FIFO and reads pop bytes in first-in, first-out order. Offset 0x7 reads the FIFO fill level. A push made while 15 bytes are held is dropped, leaving the level at 15, and `fifo_ovf` pulses for one cycle.
- R4: Command 0x01 (flush) empties the FIFO, sets the interrupt register to 0x08, sets the sequence step to 0 and leaves `irq` unchanged.
- R5: Bits 6:0 of a command byte carry the opcode. A command with bit 7 set copies the last bytes written at offsets 0x0 and 0x1 into the read view of those offsets, and a command with bit 7 clear does not. A write to offset 0x0 or 0x1 clears status bit 4 (terminal count).
- R6: Command 0x90 (DMA transfer information) pulses `dma_start` for one cycle, in the cycle after the write. `dma_len` equals the reloaded 16-bit count, and a count of 0 means 65536, and the command clears status bit 4. A later `dma_done` sets status bit 4, interrupt 0x10, sequence step 0, read-side count 0 and raises `irq`.
- R7: A read at offset 0x5 returns the interrupt register and then clears it, clears status bit 4, sets the sequence step (offset 0x6) to 4 and drops `irq`.
- R8: Bit 7 of the status byte at offset 0x4 always equals the `irq` level at the time of the read.
- R9: Command 0x03 (bus reset) sets the interrupt register to 0x80 and raises `irq` only when bit 6 of config (offset 0x8) is clear.
- R10: A selection (0x41, 0x42, 0x43) with `tgt_present` low empties the FIFO and sets status bits 6:0 to 0, interrupt to 0x20 and sequence step to 0, and raises `irq`.
- R11: A selection with `tgt_present` high empties the FIFO, sets interrupt 0x18 and sequence step 4, and raises `irq`. Status bits 6:0 depend on the command and the inputs:
  - 0x43 makes them 0x12.
  - 0x41 or 0x42 makes them 0x10 | `dev_dir_in` when `dev_len_nz` is high.
  - 0x41 or 0x42 leaves them unchanged when `dev_len_nz` is low.
  - The command offset 0x3 reads back the last command byte.
- R12: Command 0x18 (pad) sets status bits 6:0 to 0x10, interrupt to 0x08 and sequence step to 0, and leaves `irq` alone. Command 0x11 (initiator complete) ORs 0x07 into status, sets interrupt 0x08 and raises `irq`. Command 0x12 (message accept) sets interrupt 0x20 and sequence step 0, and raises `irq`.
- R13: Command 0x02 (software reset) returns every register, the FIFO and `irq` to the values of R1. This includes the config and command offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access this cycle, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data present (one cycle after request) |
| rd_data | output | 8 | Read byte |
| tgt_present | input | 1 | Target answers selection |
| dev_len_nz | input | 1 | Selected device has data to move |
| dev_dir_in | input | 1 | 1 = data flows from device to host |
| dma_start | output | 1 | One-cycle strobe starting a memory transfer |
| dma_len | output | 17 | Byte length of the started transfer |
| dma_done | input | 1 | One-cycle strobe ending the transfer |
| fifo_ovf | output | 1 | One-cycle pulse on a dropped FIFO push |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the destructive interrupt read. A core that forgot to clear status bit 4 or to set the sequence step to 4 would show a stale status or a stale sequence value on the next read. It pushes a sixteenth FIFO byte, which a core with an off-by-one limit would accept, shifting the fill level and the pop order. It checks several further corners:
- a zero transfer count, which a naive core reports as length 0 rather than 65536;
- the quiet bus-reset config bit, which a broken core ignores by raising `irq` anyway;
- the zero-length selection, which must leave status untouched;
- the software reset, which must also restore config to 0x07.

// File: rtl/scsi_core_pkg.sv
package scsi_core_pkg;

  localparam int DATA_W  = 8;
  localparam int SEQ_W   = 3;
  localparam int STAT_W  = 7;
  localparam int TC_BIT  = 4;

  // register offsets
  localparam logic [3:0] ADDR_CNT_LO  = 4'h0;
  localparam logic [3:0] ADDR_CNT_MID = 4'h1;
  localparam logic [3:0] ADDR_FIFO    = 4'h2;
  localparam logic [3:0] ADDR_CMD     = 4'h3;
  localparam logic [3:0] ADDR_STAT    = 4'h4;
  localparam logic [3:0] ADDR_INTR    = 4'h5;
  localparam logic [3:0] ADDR_SEQ     = 4'h6;
  localparam logic [3:0] ADDR_LEVEL   = 4'h7;
  localparam logic [3:0] ADDR_CFG1    = 4'h8;
  localparam logic [3:0] ADDR_SPARE0  = 4'hB;

  // opcodes (command bits 6:0)
  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_SWRST   = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_XFER    = 7'h10;
  localparam logic [6:0] OP_INITCC  = 7'h11;
  localparam logic [6:0] OP_MSGOK   = 7'h12;
  localparam logic [6:0] OP_PAD     = 7'h18;
  localparam logic [6:0] OP_SEL     = 7'h41;
  localparam logic [6:0] OP_SEL_ATN = 7'h42;
  localparam logic [6:0] OP_SEL_STP = 7'h43;

  // interrupt codes
  localparam logic [7:0] IRQ_FUNC_DONE = 8'h08;
  localparam logic [7:0] IRQ_BUS_SVC   = 8'h10;
  localparam logic [7:0] IRQ_DISCON    = 8'h20;
  localparam logic [7:0] IRQ_BUS_RST   = 8'h80;

  // effect of one command byte on the core state
  typedef struct packed {
    logic              flush;
    logic              soft_rst;
    logic              raise;
    logic              start_dma;
    logic              wr_intr;
    logic [7:0]        intr;
    logic              wr_seq;
    logic [SEQ_W-1:0]  seq;
    logic [STAT_W-1:0] stat_keep;
    logic [STAT_W-1:0] stat_set;
  } cmd_fx_t;

endpackage

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full;

  assign full = (count == LIMIT);
  assign dout = mem[rptr];

  always_ff @(posedge clk) begin
    if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= push && full;
      if (push && !full) begin
        mem[wptr] <= din;
        wptr      <= wptr + 1'b1;
        count     <= count + 1'b1;
      end else if (pop && count != '0) begin
        count <= count - 1'b1;
        if (count == CNT_W'(1)) begin
          rptr <= '0;
          wptr <= '0;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
    end
  end

  AST_FIFO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT); // R3
  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clear) |=> (ovf && $stable(count))); // R3

endmodule

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_core_pkg::*;
(
  input  logic [7:0] cmd_byte,
  input  logic       tgt_present,
  input  logic       dev_len_nz,
  input  logic       dev_dir_in,
  input  logic       quiet_busrst,
  output cmd_fx_t    fx
);

  logic is_dma;
  assign is_dma = cmd_byte[7];

  always_comb begin
    fx           = '0;
    fx.stat_keep = '1;
    case (cmd_byte[6:0])
      OP_FLUSH: begin
        fx.flush   = 1'b1;
        fx.wr_intr = 1'b1;
        fx.intr    = IRQ_FUNC_DONE;
        fx.wr_seq  = 1'b1;
      end
      OP_SWRST:  fx.soft_rst = 1'b1;
      OP_BUSRST: begin
        fx.wr_intr = 1'b1;
        fx.intr    = IRQ_BUS_RST;
        fx.raise   = !quiet_busrst;
      end
      OP_XFER: begin
        if (is_dma) begin
          fx.start_dma         = 1'b1;
          fx.stat_keep[TC_BIT] = 1'b0;
        end
      end
      OP_INITCC: begin
        fx.stat_set         = 7'h07;
        fx.stat_set[TC_BIT] = is_dma;
        fx.wr_intr          = 1'b1;
        fx.intr             = IRQ_FUNC_DONE;
        fx.raise            = 1'b1;
      end
      OP_MSGOK: begin
        fx.wr_intr = 1'b1;
        fx.intr    = IRQ_DISCON;
        fx.wr_seq  = 1'b1;
        fx.raise   = 1'b1;
      end
      OP_PAD: begin
        fx.stat_keep = '0;
        fx.stat_set  = 7'h10;
        fx.wr_intr   = 1'b1;
        fx.intr      = IRQ_FUNC_DONE;
        fx.wr_seq    = 1'b1;
      end
      OP_SEL, OP_SEL_ATN, OP_SEL_STP: begin
        fx.flush   = 1'b1;
        fx.raise   = 1'b1;
        fx.wr_intr = 1'b1;
        fx.wr_seq  = 1'b1;
        if (!tgt_present) begin
          fx.stat_keep = '0;
          fx.intr      = IRQ_DISCON;
        end else begin
          fx.intr = IRQ_BUS_SVC | IRQ_FUNC_DONE;
          fx.seq  = SEQ_W'(4);
          if (cmd_byte[6:0] == OP_SEL_STP) begin
            fx.stat_keep = '0;
            fx.stat_set  = 7'h12;
          end else if (dev_len_nz) begin
            fx.stat_keep = '0;
            fx.stat_set  = {6'h08, dev_dir_in};
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scsi_reg_core.sv
module scsi_reg_core
  import scsi_core_pkg::*;
#(
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID    = 8'h12,
  parameter logic [7:0] CFG1_RST   = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  input  logic        tgt_present,
  input  logic        dev_len_nz,
  input  logic        dev_dir_in,
  output logic        dma_start,
  output logic [16:0] dma_len,
  input  logic        dma_done,
  output logic        fifo_ovf,
  output logic        irq
);

  localparam int N_SPARE  = 5;               // offsets 0xB..0xF
  localparam int ID_SLOT  = 3;               // 0xE inside the spare block
  localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);
  localparam logic [16:0] FULL_SPAN = 17'h10000;

  logic [7:0]        lo_r, mid_r, lo_w, mid_w, cmd_q, intr_q, cfg1_q;
  logic [STAT_W-1:0] stat_q;
  logic [SEQ_W-1:0]  seq_q;
  logic              irq_q, busy_q, start_q;
  logic [16:0]       len_q;
  logic [7:0]        spare_q [N_SPARE];

  logic [7:0]        lo_rn, mid_rn, lo_wn, mid_wn, cmd_n, intr_n, cfg1_n;
  logic [STAT_W-1:0] stat_n;
  logic [SEQ_W-1:0]  seq_n;
  logic              irq_n, busy_n, start_n;
  logic [16:0]       len_n;
  logic [7:0]        spare_n [N_SPARE];

  logic              rd_req, wr_req, cmd_wr, soft_rst, fifo_clr;
  logic [2:0]        sp_idx;
  logic [7:0]        view;
  logic [7:0]        fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  cmd_fx_t           fx;

  assign rd_req   = bus_valid && !bus_write;
  assign wr_req   = bus_valid && bus_write;
  assign cmd_wr   = wr_req && bus_addr == ADDR_CMD;
  assign soft_rst = cmd_wr && fx.soft_rst;
  assign fifo_clr = !rst_n || soft_rst || (cmd_wr && fx.flush);
  assign sp_idx   = 3'(bus_addr - ADDR_SPARE0);

  scsi_cmd_decode u_decode (
    .cmd_byte     (bus_wdata),
    .tgt_present  (tgt_present),
    .dev_len_nz   (dev_len_nz),
    .dev_dir_in   (dev_dir_in),
    .quiet_busrst (cfg1_q[6]),
    .fx           (fx)
  );

  scsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fifo_clr),
    .push  (wr_req && bus_addr == ADDR_FIFO),
    .pop   (rd_req && bus_addr == ADDR_FIFO),
    .din   (bus_wdata),
    .dout  (fifo_dout),
    .count (fifo_cnt),
    .ovf   (fifo_ovf)
  );

  // read view
  always_comb begin
    case (bus_addr)
      ADDR_CNT_LO:  view = lo_r;
      ADDR_CNT_MID: view = mid_r;
      ADDR_FIFO:    view = fifo_dout;
      ADDR_CMD:     view = cmd_q;
      ADDR_STAT:    view = {irq_q, stat_q};
      ADDR_INTR:    view = intr_q;
      ADDR_SEQ:     view = 8'(seq_q);
      ADDR_LEVEL:   view = 8'(fifo_cnt);
      ADDR_CFG1:    view = cfg1_q;
      4'hB, 4'hC, 4'hD, 4'hE, 4'hF: view = spare_q[sp_idx];
      default:      view = '0;
    endcase
  end

  // next state
  always_comb begin
    lo_rn = lo_r;  mid_rn = mid_r;  lo_wn = lo_w;  mid_wn = mid_w;
    cmd_n = cmd_q; intr_n = intr_q; cfg1_n = cfg1_q;
    stat_n = stat_q; seq_n = seq_q; irq_n = irq_q;
    busy_n = busy_q; start_n = 1'b0; len_n = len_q;
    for (int i = 0; i < N_SPARE; i++) spare_n[i] = spare_q[i];

    if (rd_req && bus_addr == ADDR_INTR) begin
      intr_n         = '0;
      stat_n[TC_BIT] = 1'b0;
      seq_n          = SEQ_W'(4);
      irq_n          = 1'b0;
    end

    if (wr_req) begin
      case (bus_addr)
        ADDR_CNT_LO:  begin lo_wn  = bus_wdata; stat_n[TC_BIT] = 1'b0; end
        ADDR_CNT_MID: begin mid_wn = bus_wdata; stat_n[TC_BIT] = 1'b0; end
        ADDR_CMD: begin
          cmd_n = bus_wdata;
          if (bus_wdata[7]) begin
            lo_rn  = lo_w;
            mid_rn = mid_w;
          end
          stat_n = (stat_q & fx.stat_keep) | fx.stat_set;
          if (fx.wr_intr) intr_n = fx.intr;
          if (fx.wr_seq)  seq_n  = fx.seq;
          if (fx.raise)   irq_n  = 1'b1;
          if (fx.start_dma) begin
            busy_n  = 1'b1;
            start_n = 1'b1;
            len_n   = ({mid_w, lo_w} == 16'h0) ? FULL_SPAN : {1'b0, mid_w, lo_w};
          end
        end
        ADDR_CFG1: cfg1_n = bus_wdata;
        4'hB, 4'hC, 4'hD, 4'hE, 4'hF: spare_n[sp_idx] = bus_wdata;
        default: ;
      endcase
    end

    if (dma_done && busy_q) begin
      busy_n         = 1'b0;
      stat_n[TC_BIT] = 1'b1;
      intr_n         = IRQ_BUS_SVC;
      seq_n          = '0;
      lo_rn          = '0;
      mid_rn         = '0;
      irq_n          = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      lo_r <= '0; mid_r <= '0; lo_w <= '0; mid_w <= '0;
      cmd_q <= '0; intr_q <= '0; cfg1_q <= CFG1_RST;
      stat_q <= '0; seq_q <= '0; irq_q <= 1'b0;
      busy_q <= 1'b0; start_q <= 1'b0; len_q <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
      for (int i = 0; i < N_SPARE; i++) spare_q[i] <= (i == ID_SLOT) ? CHIP_ID : 8'h00;
    end else begin
      lo_r <= lo_rn; mid_r <= mid_rn; lo_w <= lo_wn; mid_w <= mid_wn;
      cmd_q <= cmd_n; intr_q <= intr_n; cfg1_q <= cfg1_n;
      stat_q <= stat_n; seq_q <= seq_n; irq_q <= irq_n;
      busy_q <= busy_n; start_q <= start_n; len_q <= len_n;
      rd_valid <= rd_req;
      rd_data  <= view;
      for (int i = 0; i < N_SPARE; i++) spare_q[i] <= spare_n[i];
    end
  end

  assign irq       = irq_q;
  assign dma_start = start_q;
  assign dma_len   = len_q;

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R2
  AST_STAT_MIRRORS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == ADDR_STAT) |=> (rd_data[7] == $past(irq))); // R8
  AST_INTR_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == ADDR_INTR && !dma_done) |=> !irq); // R7
  AST_QUIET_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[6:0] == OP_BUSRST && cfg1_q[6] && !irq && !dma_done) |=> !irq); // R9
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start); // R6

endmodule

// File: tb/test_scsi_reg_core.sv
module test_scsi_reg_core;

  localparam logic [7:0] CHIP = 8'h12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0, bw = 1'b0;
  logic [3:0]  ba = '0;
  logic [7:0]  bd = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        tgt = 1'b0, lnz = 1'b0, din = 1'b0;
  logic        dma_start, dma_done = 1'b0, fifo_ovf, irq;
  logic [16:0] dma_len;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  scsi_reg_core #(.CHIP_ID(CHIP)) i_scsi_reg_core (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_wdata(bd), .rd_valid(rd_valid), .rd_data(rd_data), .tgt_present(tgt),
    .dev_len_nz(lnz), .dev_dir_in(din), .dma_start(dma_start), .dma_len(dma_len),
    .dma_done(dma_done), .fifo_ovf(fifo_ovf), .irq(irq));

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected rd_valid, data %02h expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: read %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [16:0] act, input logic [16:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bv = 1'b1; bw = 1'b1; ba = a; bd = d;
    @(negedge clk); bv = 1'b0; bw = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk); bv = 1'b1; bw = 1'b0; ba = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bv = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 irq", irq, 0);
    rd(4'h0, 8'h00, "R1 cnt lo"); rd(4'h1, 8'h00, "R1 cnt mid");
    rd(4'h3, 8'h00, "R1 cmd");    rd(4'h4, 8'h00, "R1 status");
    rd(4'h5, 8'h00, "R1 intr");   rd(4'h6, 8'h04, "R1 seq after intr read");
    rd(4'h7, 8'h00, "R1 level");  rd(4'h8, 8'h07, "R1 cfg");
    rd(4'hE, CHIP,  "R1 chip id");

    // R3 FIFO fill, overrun, order
    for (int i = 1; i <= 15; i++) wr(4'h2, 8'(i));
    chk("R3 no ovf at 15", fifo_ovf, 0);
    wr(4'h2, 8'h10);
    chk("R3 ovf pulse", fifo_ovf, 1);
    rd(4'h7, 8'd15, "R3 level capped");
    rd(4'h2, 8'h01, "R3 pop1"); rd(4'h2, 8'h02, "R3 pop2"); rd(4'h2, 8'h03, "R3 pop3");
    rd(4'h7, 8'd12, "R3 level after pops");

    // R4 flush
    wr(4'h3, 8'h01);
    chk("R4 irq unchanged", irq, 0);
    rd(4'h6, 8'h00, "R4 seq"); rd(4'h7, 8'h00, "R4 level");
    rd(4'h5, 8'h08, "R4 intr");
    rd(4'h6, 8'h04, "R7 seq set by intr read");

    // R5 reload only with DMA bit
    wr(4'h0, 8'h34); wr(4'h1, 8'h12);
    rd(4'h0, 8'h00, "R5 no reload on write");
    wr(4'h3, 8'h00);
    rd(4'h0, 8'h00, "R5 no reload on plain cmd");
    wr(4'h3, 8'h80);
    rd(4'h0, 8'h34, "R5 reload lo"); rd(4'h1, 8'h12, "R5 reload mid");

    // R6 DMA transfer
    wr(4'h3, 8'h90);
    chk("R6 start pulse", dma_start, 1);
    chk("R6 len", dma_len, 17'h01234);
    @(negedge clk);
    chk("R6 start ends", dma_start, 0);
    done_pulse();
    chk("R6 irq on done", irq, 1);
    rd(4'h4, 8'h90, "R6 status TC+irq");
    rd(4'h0, 8'h00, "R6 cnt lo zero"); rd(4'h1, 8'h00, "R6 cnt mid zero");
    rd(4'h6, 8'h00, "R6 seq");
    rd(4'h5, 8'h10, "R7 intr old value");
    chk("R7 irq dropped", irq, 0);
    rd(4'h5, 8'h00, "R7 intr cleared");
    rd(4'h4, 8'h00, "R8 status TC and irq bit clear");
    wr(4'h0, 8'h00); wr(4'h1, 8'h00);
    wr(4'h3, 8'h90);
    chk("R6 zero count len", dma_len, 17'h10000);
    done_pulse();
    wr(4'h0, 8'h05);
    rd(4'h4, 8'h80, "R5 counter write clears TC");
    rd(4'h5, 8'h10, "R7 intr");

    // R9 bus reset
    wr(4'h3, 8'h03);
    chk("R9 irq raised", irq, 1);
    rd(4'h5, 8'h80, "R9 intr");
    wr(4'h8, 8'h47);
    wr(4'h3, 8'h03);
    chk("R9 quiet irq", irq, 0);
    rd(4'h5, 8'h80, "R9 quiet intr");
    rd(4'h8, 8'h47, "R9 cfg readback");

    // R10 selection without target
    wr(4'h2, 8'hAA); wr(4'h2, 8'hBB);
    wr(4'h3, 8'h41);
    chk("R10 irq", irq, 1);
    rd(4'h4, 8'h80, "R10 status"); rd(4'h6, 8'h00, "R10 seq");
    rd(4'h7, 8'h00, "R10 fifo cleared"); rd(4'h5, 8'h20, "R10 intr");

    // R11 selections with target
    tgt = 1'b1; lnz = 1'b1; din = 1'b1;
    wr(4'h3, 8'h42);
    rd(4'h4, 8'h91, "R11 status data in"); rd(4'h6, 8'h04, "R11 seq");
    rd(4'h3, 8'h42, "R11 cmd readback");   rd(4'h5, 8'h18, "R11 intr");
    din = 1'b0;
    wr(4'h3, 8'h41);
    rd(4'h4, 8'h90, "R11 status data out"); rd(4'h5, 8'h18, "R11 intr");
    wr(4'h3, 8'h43);
    rd(4'h4, 8'h92, "R11 stop status");     rd(4'h5, 8'h18, "R11 intr");
    lnz = 1'b0;
    wr(4'h3, 8'h41);
    rd(4'h4, 8'h82, "R11 zero length keeps status"); rd(4'h5, 8'h18, "R11 intr");

    // R12 pad, initiator complete, message accept
    wr(4'h3, 8'h18);
    chk("R12 pad no irq", irq, 0);
    rd(4'h4, 8'h10, "R12 pad status"); rd(4'h6, 8'h00, "R12 pad seq");
    rd(4'h5, 8'h08, "R12 pad intr");
    wr(4'h3, 8'h11);
    rd(4'h4, 8'h87, "R12 initcc status"); rd(4'h5, 8'h08, "R12 initcc intr");
    wr(4'h3, 8'h12);
    chk("R12 msg irq", irq, 1);
    rd(4'h6, 8'h00, "R12 msg seq"); rd(4'h5, 8'h20, "R12 msg intr");

    // R13 software reset
    wr(4'h8, 8'h55); wr(4'h2, 8'h11); wr(4'hE, 8'h99);
    wr(4'h3, 8'h12);
    wr(4'h3, 8'h02);
    chk("R13 irq low", irq, 0);
    rd(4'h8, 8'h07, "R13 cfg"); rd(4'h7, 8'h00, "R13 level");
    rd(4'h4, 8'h00, "R13 status"); rd(4'hE, CHIP, "R13 chip id");
    rd(4'h3, 8'h00, "R13 cmd"); rd(4'h5, 8'h00, "R13 intr");

    repeat (4) @(negedge clk);
    chk("R2 all reads returned", 17'(exp_q.size()), 0);
    finished = 1;
    finish_up();
  end

endmodule